// File: doc/BRIEF.md
# ADC Convert-and-Read Sequencer

This block runs a serial successive-approximation converter through repeated conversion cycles without software involvement. Straight after reset it sends one configuration frame. After that, each cycle lowers an active-low convert-start line for a short, fixed pulse and lets a settling window pass. It then polls the converter's end-of-conversion line until the conversion has finished. Only after that does it open a serial transfer that sends a fixed read command and shifts the result in. So the result is read while the converter is already sampling again, never while it is still converting.

A conversion may never begin: end-of-conversion then stays high through the pulse and the settling window. In that case the sequencer issues the convert-start pulse again, up to a parameter limit. A conversion may also begin and never finish. A second limit bounds how long the sequencer waits for that. Either failure gives a one-cycle error strobe and a return to idle. A start strobe asks for one conversion, and a free-run level asks for conversions back to back. A tag-mode input lengthens the read transfer by one byte so that a trailing tag byte can be checked.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, and before any convert-start pulse, the block sends one frame of 16 serial clocks. Its SDI word, MSB first, is the write opcode 4'hE followed by the 12-bit configuration value (default 12'h7FF), giving 16'hE7FF.
- R2: The convert-start line idles high. Each conversion begins with a low pulse of exactly PULSE_CYC clock cycles. The line is never low while chip-select is low.
- R3: If end-of-conversion is not seen low during the pulse or the SETTLE_CYC settling window after it, the pulse is issued again. After MAX_PULSES pulses that all fail, the block gives a one-cycle err_o and returns to idle without a transfer.
- R4: Chip-select falls for a read only after end-of-conversion has gone low and then returned high. SCLK stays low whenever chip-select is high.
- R5: A read frame with tag mode off has 16 SCLK periods and the SDI word 16'hD000, MSB first. SDI changes after a falling SCLK edge and is stable at the rising edge. Each SCLK level lasts CLK_DIV clock cycles.
- R6: The first bit received is the MSB of the result. Each read gives a one-cycle res_valid_o, and res_data_o holds its value until the next res_valid_o.
- R7: tag_en_i is sampled when a read frame starts. When it is set, the frame has 24 SCLK periods: SDI sends 16'hD000 and then 8 zero bits, and the last 8 bits received appear on res_tag_o. res_tag_ok_o is 1 exactly when that byte is 8'h20. When tag mode is off, res_tag_o and res_tag_ok_o are 0.
- R8: If end-of-conversion does not return high within POLL_LIMIT cycles after the settling window, the block gives a one-cycle err_o, makes no transfer, and returns to idle. err_o and res_valid_o are never high together.
- R9: One start_i strobe gives exactly one convert-start pulse and one result. While free_run_i is high, a new conversion begins straight after each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request for a single conversion |
| free_run_i | input | 1 | Level: convert continuously |
| tag_en_i | input | 1 | Extend reads by a trailing tag byte |
| adc_eoc_i | input | 1 | End-of-conversion from the converter (low while converting) |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_convst_n_o | output | 1 | Active-low convert-start |
| adc_cs_n_o | output | 1 | Active-low chip-select |
| adc_sclk_o | output | 1 | Serial clock, idles low |
| adc_sdi_o | output | 1 | Serial data to the converter |
| res_valid_o | output | 1 | One-cycle strobe: new result |
| res_data_o | output | 16 | Last conversion result |
| res_tag_o | output | 8 | Last tag byte (0 when tag mode is off) |
| res_tag_ok_o | output | 1 | Tag byte equals 8'h20 |
| err_o | output | 1 | One-cycle strobe: retry limit or poll timeout reached |

## Verification
The bench builds the block with CLK_DIV=2, PULSE_CYC=3, SETTLE_CYC=12, POLL_LIMIT=60 and MAX_PULSES=3. With these short windows, exhausting the retry limit and running out the poll timeout each take only tens of cycles, so both error paths are reached quickly. A two-cycle SCLK level still leaves a gap between each SDI change and the next sampling edge. A behavioural converter model in the bench can skip conversion starts, hang mid-conversion and return chosen tag bytes, which drives every retry, timeout and tag outcome.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int FRAME_MAX = 24;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int WORD_W    = 16;
    localparam int TAG_W     = 8;

    localparam logic [15:0] READ_CMD = 16'hD000;
    localparam logic [3:0]  CFG_OP   = 4'hE;
    localparam logic [7:0]  TAG_GOOD = 8'h20;

    typedef enum logic [2:0] {
        S_BOOT,
        S_BOOT_WAIT,
        S_IDLE,
        S_PULSE,
        S_SETTLE,
        S_POLL,
        S_READ,
        S_READ_WAIT
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        logic              tag_ok;
    } sample_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input logic cfg, input logic tag);
        return (cfg || !tag) ? LEN_W'(16) : LEN_W'(24);
    endfunction

    function automatic logic [FRAME_MAX-1:0] frame_word(input logic cfg, input logic [11:0] cfg_val);
        return cfg ? {CFG_OP, cfg_val, 8'h00} : {READ_CMD, 8'h00};
    endfunction

    function automatic sample_t unpack_rx(input logic [FRAME_MAX-1:0] rx, input logic tag);
        sample_t s;
        s.data   = tag ? rx[23:8] : rx[15:0];
        s.tag    = tag ? rx[7:0] : '0;
        s.tag_ok = tag && (rx[7:0] == TAG_GOOD);
        return s;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= load_val_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/adc_seq_spi.sv
module adc_seq_spi
    import adc_seq_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [FRAME_MAX-1:0] tx_word,
    input  logic [LEN_W-1:0]     nbits,
    input  logic                 sdo_i,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic                 sdi_o,
    output logic [FRAME_MAX-1:0] rx_word_o,
    output logic                 done_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic                 active;
    logic [DW-1:0]        div_cnt;
    logic [LEN_W-1:0]     bit_cnt;
    logic [LEN_W-1:0]     nb;
    logic [FRAME_MAX-1:0] tx_sh;
    logic [FRAME_MAX-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cs_n_o  <= 1'b1;
            sclk_o  <= 1'b0;
            done_o  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            nb      <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    cs_n_o  <= 1'b0;
                    sclk_o  <= 1'b0;
                    tx_sh   <= tx_word;
                    rx_sh   <= '0;
                    nb      <= nbits;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                end
            end else if (div_cnt == DW'(DIV - 1)) begin
                div_cnt <= '0;
                if (!sclk_o) begin
                    // rising edge: capture converter data
                    sclk_o <= 1'b1;
                    rx_sh  <= {rx_sh[FRAME_MAX-2:0], sdo_i};
                end else begin
                    // falling edge: present next command bit
                    sclk_o <= 1'b0;
                    tx_sh  <= {tx_sh[FRAME_MAX-2:0], 1'b0};
                    if (bit_cnt == nb - 1'b1) begin
                        active <= 1'b0;
                        cs_n_o <= 1'b1;
                        done_o <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign sdi_o     = active & tx_sh[FRAME_MAX-1];
    assign rx_word_o = rx_sh;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int PULSE_CYC  = 8,
    parameter int SETTLE_CYC = 125,
    parameter int POLL_LIMIT = 2000,
    parameter int MAX_PULSES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic free_run_i,
    input  logic eoc_i,
    input  logic spi_done_i,
    output logic spi_go_o,
    output logic spi_cfg_o,
    output logic convst_n_o,
    output logic err_o,
    output logic capture_o
);
    localparam int TW  = $clog2(max3(PULSE_CYC, SETTLE_CYC, POLL_LIMIT) + 1);
    localparam int PCW = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0] PULSE_V  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] POLL_V   = TW'(POLL_LIMIT - 1);

    seq_state_t     state, state_n;
    logic [PCW-1:0] pulse_cnt, pulse_n;
    logic           fell_seen, fell_n;
    logic           t_load, t_exp;
    logic [TW-1:0]  t_val;
    logic           err_n;

    adc_seq_timer #(.W(TW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (t_load),
        .load_val_i(t_val),
        .expired_o (t_exp)
    );

    always_comb begin
        state_n   = state;
        pulse_n   = pulse_cnt;
        fell_n    = fell_seen;
        t_load    = 1'b0;
        t_val     = '0;
        spi_go_o  = 1'b0;
        spi_cfg_o = 1'b0;
        err_n     = 1'b0;
        capture_o = 1'b0;
        unique case (state)
            S_BOOT: begin
                spi_go_o  = 1'b1;
                spi_cfg_o = 1'b1;
                state_n   = S_BOOT_WAIT;
            end
            S_BOOT_WAIT: begin
                if (spi_done_i) state_n = S_IDLE;
            end
            S_IDLE: begin
                if (start_i || free_run_i) begin
                    state_n = S_PULSE;
                    t_load  = 1'b1;
                    t_val   = PULSE_V;
                    pulse_n = PCW'(1);
                    fell_n  = 1'b0;
                end
            end
            S_PULSE: begin
                if (!eoc_i) fell_n = 1'b1;
                if (t_exp) begin
                    state_n = S_SETTLE;
                    t_load  = 1'b1;
                    t_val   = SETTLE_V;
                end
            end
            S_SETTLE: begin
                if (!eoc_i) fell_n = 1'b1;
                if (t_exp) begin
                    if (fell_seen || !eoc_i) begin
                        state_n = S_POLL;
                        t_load  = 1'b1;
                        t_val   = POLL_V;
                    end else if (pulse_cnt == PCW'(MAX_PULSES)) begin
                        state_n = S_IDLE;
                        err_n   = 1'b1;
                    end else begin
                        state_n = S_PULSE;
                        t_load  = 1'b1;
                        t_val   = PULSE_V;
                        pulse_n = pulse_cnt + 1'b1;
                        fell_n  = 1'b0;
                    end
                end
            end
            S_POLL: begin
                if (eoc_i) begin
                    state_n = S_READ;
                end else if (t_exp) begin
                    state_n = S_IDLE;
                    err_n   = 1'b1;
                end
            end
            S_READ: begin
                spi_go_o = 1'b1;
                state_n  = S_READ_WAIT;
            end
            S_READ_WAIT: begin
                if (spi_done_i) begin
                    capture_o = 1'b1;
                    if (free_run_i) begin
                        state_n = S_PULSE;
                        t_load  = 1'b1;
                        t_val   = PULSE_V;
                        pulse_n = PCW'(1);
                        fell_n  = 1'b0;
                    end else begin
                        state_n = S_IDLE;
                    end
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_BOOT;
            pulse_cnt  <= '0;
            fell_seen  <= 1'b0;
            convst_n_o <= 1'b1;
            err_o      <= 1'b0;
        end else begin
            state      <= state_n;
            pulse_cnt  <= pulse_n;
            fell_seen  <= fell_n;
            convst_n_o <= (state_n != S_PULSE);
            err_o      <= err_n;
        end
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int          CLK_DIV    = 4,
    parameter int          PULSE_CYC  = 8,
    parameter int          SETTLE_CYC = 125,
    parameter int          POLL_LIMIT = 2000,
    parameter int          MAX_PULSES = 4,
    parameter logic [11:0] CFG_VALUE  = 12'h7FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        free_run_i,
    input  logic        tag_en_i,
    input  logic        adc_eoc_i,
    input  logic        adc_sdo_i,
    output logic        adc_convst_n_o,
    output logic        adc_cs_n_o,
    output logic        adc_sclk_o,
    output logic        adc_sdi_o,
    output logic        res_valid_o,
    output logic [15:0] res_data_o,
    output logic [7:0]  res_tag_o,
    output logic        res_tag_ok_o,
    output logic        err_o
);
    logic                 eoc_s1, eoc_s2;
    logic                 spi_go, spi_cfg, spi_done, capture;
    logic                 tag_q;
    logic [FRAME_MAX-1:0] rx_word;
    sample_t              res_q;

    // two-stage synchronizer for the asynchronous end-of-conversion line
    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_s1 <= 1'b1;
            eoc_s2 <= 1'b1;
        end else begin
            eoc_s1 <= adc_eoc_i;
            eoc_s2 <= eoc_s1;
        end
    end

    adc_seq_fsm #(
        .PULSE_CYC (PULSE_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .POLL_LIMIT(POLL_LIMIT),
        .MAX_PULSES(MAX_PULSES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .free_run_i(free_run_i),
        .eoc_i     (eoc_s2),
        .spi_done_i(spi_done),
        .spi_go_o  (spi_go),
        .spi_cfg_o (spi_cfg),
        .convst_n_o(adc_convst_n_o),
        .err_o     (err_o),
        .capture_o (capture)
    );

    adc_seq_spi #(.DIV(CLK_DIV)) u_spi (
        .clk      (clk),
        .rst      (rst),
        .go       (spi_go),
        .tx_word  (frame_word(spi_cfg, CFG_VALUE)),
        .nbits    (frame_len(spi_cfg, tag_en_i)),
        .sdo_i    (adc_sdo_i),
        .cs_n_o   (adc_cs_n_o),
        .sclk_o   (adc_sclk_o),
        .sdi_o    (adc_sdi_o),
        .rx_word_o(rx_word),
        .done_o   (spi_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q       <= 1'b0;
            res_q       <= '0;
            res_valid_o <= 1'b0;
        end else begin
            if (spi_go && !spi_cfg) tag_q <= tag_en_i;
            res_valid_o <= capture;
            if (capture) res_q <= unpack_rx(rx_word, tag_q);
        end
    end

    assign res_data_o   = res_q.data;
    assign res_tag_o    = res_q.tag;
    assign res_tag_ok_o = res_q.tag_ok;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int PULSE_CYC = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        convst_n,
    input logic        cs_n,
    input logic        sclk,
    input logic        eoc,
    input logic        valid,
    input logic [15:0] data,
    input logic [7:0]  tag,
    input logic        tag_ok,
    input logic        err
);
    int   low_cnt;
    logic boot_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= 0;
            boot_done <= 1'b0;
        end else begin
            low_cnt <= convst_n ? 0 : low_cnt + 1;
            if (cs_n && !boot_done && low_cnt == 0 && $rose(cs_n)) boot_done <= 1'b1;
        end
    end

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(convst_n) |-> low_cnt == PULSE_CYC);

    p_no_convst_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        !convst_n |-> cs_n);

    p_cs_after_eoc_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && boot_done) |-> eoc);

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !sclk);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(data));

    p_tag_match_r7: assert property (@(posedge clk) disable iff (rst)
        tag_ok |-> tag == 8'h20);

    p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> !valid);
endmodule

bind adc_conv_seq adc_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .convst_n(adc_convst_n_o),
    .cs_n    (adc_cs_n_o),
    .sclk    (adc_sclk_o),
    .eoc     (adc_eoc_i),
    .valid   (res_valid_o),
    .data    (res_data_o),
    .tag     (res_tag_o),
    .tag_ok  (res_tag_ok_o),
    .err     (err_o)
);

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
    localparam int CLK_DIV    = 2;
    localparam int PULSE_CYC  = 3;
    localparam int SETTLE_CYC = 12;
    localparam int POLL_LIMIT = 60;
    localparam int MAX_PULSES = 3;
    localparam int CONV_LEN   = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        free_run = 1'b0;
    logic        tag_en = 1'b0;
    logic        eoc = 1'b1;
    logic        sdo = 1'b0;
    logic        convst_n, cs_n, sclk, sdi, valid, tag_ok, err;
    logic [15:0] data;
    logic [7:0]  tag;

    int errors = 0;
    int checks = 0;

    // converter model state
    int          n_pulse = 0;
    int          frames = 0;
    int          skip_until = 0;
    bit          hang = 1'b0;
    bit          pat_en = 1'b0;
    logic [15:0] pat_val = '0;
    logic [7:0]  next_tag = '0;
    logic [15:0] cur_res = '0;
    logic [7:0]  cur_tag = '0;
    logic [15:0] sent_res = '0;
    logic [7:0]  sent_tag = '0;
    logic [23:0] sh = '0;
    logic [23:0] rxw = '0;
    logic [23:0] last_rx = '0;
    int          nclk = 0;
    int          last_n = 0;
    int          fall_cd = 0;
    int          conv_cd = 0;
    logic        eoc_at_cs = 1'b0;
    time         t_cv_fall = 0;
    time         t_rise = 0;
    time         pulse_w = 0;
    time         half_ns = 0;
    logic        cs_p = 1'b1, sclk_p = 1'b0, cv_p = 1'b1;

    always #4 clk = ~clk;

    adc_conv_seq #(
        .CLK_DIV   (CLK_DIV),
        .PULSE_CYC (PULSE_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .POLL_LIMIT(POLL_LIMIT),
        .MAX_PULSES(MAX_PULSES),
        .CFG_VALUE (12'h7FF)
    ) u_adc_conv_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .free_run_i    (free_run),
        .tag_en_i      (tag_en),
        .adc_eoc_i     (eoc),
        .adc_sdo_i     (sdo),
        .adc_convst_n_o(convst_n),
        .adc_cs_n_o    (cs_n),
        .adc_sclk_o    (sclk),
        .adc_sdi_o     (sdi),
        .res_valid_o   (valid),
        .res_data_o    (data),
        .res_tag_o     (tag),
        .res_tag_ok_o  (tag_ok),
        .err_o         (err)
    );

    // behavioural converter, evaluated half a cycle away from the active edge
    always @(negedge clk) begin
        if (rst === 1'b0) begin
            if (cv_p && !convst_n) begin
                n_pulse   = n_pulse + 1;
                t_cv_fall = $time;
            end
            if (!cv_p && convst_n) begin
                pulse_w = $time - t_cv_fall;
                if (n_pulse > skip_until) fall_cd = 3;
            end
            if (fall_cd > 0) begin
                fall_cd = fall_cd - 1;
                if (fall_cd == 0) begin
                    eoc     = 1'b0;
                    cur_res = pat_en ? pat_val : 16'($urandom);
                    cur_tag = next_tag;
                    conv_cd = CONV_LEN;
                end
            end else if (conv_cd > 0) begin
                conv_cd = conv_cd - 1;
            end else if (!hang) begin
                eoc = 1'b1;
            end
            if (cs_p && !cs_n) begin
                sh        = {cur_res, cur_tag};
                sent_res  = cur_res;
                sent_tag  = cur_tag;
                sdo       = sh[23];
                rxw       = '0;
                nclk      = 0;
                eoc_at_cs = eoc;
            end else if (!cs_n && sclk_p && !sclk) begin
                sh      = {sh[22:0], 1'b0};
                sdo     = sh[23];
                half_ns = $time - t_rise;
            end
            if (!cs_n && !sclk_p && sclk) begin
                rxw    = {rxw[22:0], sdi};
                nclk   = nclk + 1;
                t_rise = $time;
            end
            if (!cs_p && cs_n) begin
                frames  = frames + 1;
                last_rx = rxw;
                last_n  = nclk;
            end
        end
        cs_p   = cs_n;
        sclk_p = sclk;
        cv_p   = convst_n;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_valid(input int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (valid) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_err(input int lim, output bit got, output bit saw_valid);
        got = 1'b0;
        saw_valid = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (valid) saw_valid = 1'b1;
            if (err) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    function automatic logic [15:0] cmd_of(input logic [23:0] r, input bit tg);
        return tg ? r[23:8] : r[15:0];
    endfunction

    // check one completed read against the model
    task automatic check_read(input bit tg, input int p0, input int f0, input int npulse);
        chk(data == sent_res, "R6 result data", data, sent_res);
        chk(cmd_of(last_rx, tg) == 16'hD000, "R5 read command", cmd_of(last_rx, tg), 16'hD000);
        chk(last_n == (tg ? 24 : 16), "R7 frame length", last_n, tg ? 24 : 16);
        if (tg) chk(last_rx[7:0] == 8'h00, "R7 trailing SDI zero", last_rx[7:0], 0);
        chk(tag == (tg ? sent_tag : 8'h00), "R7 tag byte", tag, tg ? sent_tag : 8'h00);
        chk(tag_ok == (tg && sent_tag == 8'h20), "R7 tag ok", tag_ok, (tg && sent_tag == 8'h20));
        chk(pulse_w == PULSE_CYC * 8, "R2 pulse width", pulse_w, PULSE_CYC * 8);
        chk(eoc_at_cs == 1'b1, "R4 eoc high at cs", eoc_at_cs, 1);
        chk(half_ns == CLK_DIV * 8, "R5 sclk level", half_ns, CLK_DIV * 8);
        chk(n_pulse == p0 + npulse, "R9 pulse count", n_pulse - p0, npulse);
        chk(frames == f0 + 1, "R9 frame count", frames - f0, 1);
    endtask

    task automatic run_one(input bit tg, input logic [7:0] tv, input int npulse);
        int p0, f0;
        bit got;
        p0 = n_pulse;
        f0 = frames;
        tag_en = tg;
        next_tag = tv;
        pulse_start();
        wait_valid(1000, got);
        chk(got, "R9 result arrives", got, 1);
        if (got) check_read(tg, p0, f0, npulse);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p0, f0;
        bit got, sv;
        void'($urandom(32'h5eed));

        repeat (4) @(negedge clk);
        // R2 R4: reset state
        chk(convst_n == 1'b1, "R2 reset convst", convst_n, 1);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R4 reset cs/sclk", {cs_n, sclk}, 2'b10);
        chk(valid == 1'b0 && err == 1'b0, "R6 reset strobes", {valid, err}, 0);
        rst = 1'b0;

        // R1: configuration frame
        for (int i = 0; i < 500 && frames == 0; i++) @(negedge clk);
        chk(last_rx[15:0] == 16'hE7FF, "R1 config word", last_rx[15:0], 16'hE7FF);
        chk(last_n == 16, "R1 config length", last_n, 16);
        chk(n_pulse == 0, "R1 no pulse before config", n_pulse, 0);
        repeat (10) @(negedge clk);

        // directed corner values
        pat_en = 1'b1;
        pat_val = 16'hFFFF; run_one(1'b0, 8'h00, 1);
        pat_val = 16'h0000; run_one(1'b1, 8'h20, 1);
        pat_val = 16'h8001; run_one(1'b1, 8'h21, 1);
        pat_en = 1'b0;

        // random mix of tag mode and tag values
        for (int k = 0; k < 8; k++) begin
            bit tg;
            logic [7:0] tv;
            tg = 1'($urandom);
            tv = ($urandom % 2) ? 8'h20 : 8'($urandom);
            run_one(tg, tv, 1);
        end

        // R6: result held until next strobe
        repeat (40) @(negedge clk);
        chk(data == sent_res, "R6 data held", data, sent_res);

        // R3: one missed conversion start -> second pulse
        skip_until = n_pulse + 1;
        run_one(1'b0, 8'h00, 2);
        skip_until = 0;

        // R3: all pulses missed -> error after MAX_PULSES
        p0 = n_pulse;
        f0 = frames;
        skip_until = n_pulse + 100;
        pulse_start();
        wait_err(1000, got, sv);
        chk(got, "R3 error after retries", got, 1);
        chk(!sv, "R3 no result on error", sv, 0);
        chk(n_pulse == p0 + MAX_PULSES, "R3 pulse limit", n_pulse - p0, MAX_PULSES);
        chk(frames == f0, "R3 no transfer", frames - f0, 0);
        skip_until = 0;
        repeat (20) @(negedge clk);

        // R8: conversion never ends -> poll timeout
        f0 = frames;
        hang = 1'b1;
        pulse_start();
        wait_err(1000, got, sv);
        chk(got, "R8 poll timeout error", got, 1);
        chk(!sv, "R8 no result on timeout", sv, 0);
        chk(frames == f0, "R8 no transfer", frames - f0, 0);
        hang = 1'b0;
        repeat (40) @(negedge clk);
        chk(eoc == 1'b1 && cs_n == 1'b1, "R8 back to idle", {eoc, cs_n}, 2'b11);

        // R9: single shot gives no further conversion
        run_one(1'b1, 8'h20, 1);
        p0 = n_pulse;
        repeat (300) @(negedge clk);
        chk(n_pulse == p0, "R9 single shot idle", n_pulse - p0, 0);

        // R9: free-running conversions
        tag_en = 1'b0;
        free_run = 1'b1;
        p0 = n_pulse;
        for (int k = 0; k < 4; k++) begin
            wait_valid(1000, got);
            chk(got, "R9 free-run result", got, 1);
            chk(data == sent_res, "R6 free-run data", data, sent_res);
        end
        chk(n_pulse == p0 + 4 || n_pulse == p0 + 5, "R9 free-run pulses", n_pulse - p0, 4);
        free_run = 1'b0;
        wait_valid(1000, got);
        repeat (20) @(negedge clk);
        p0 = n_pulse;
        repeat (300) @(negedge clk);
        chk(n_pulse == p0, "R9 free-run stops", n_pulse - p0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule